// File: doc/BRIEF.md
# Interrupt Rate Pacer

This block sits between a bank of 40 raw interrupt lines and an interrupt controller, and it limits the event rate on up to four chosen lines. One shared prescale counter divides the bus clock into fixed time slots. Software normally sets the slot to the number of bus clocks in 4 µs. Each of the four pacers watches one selected line. In each slot it passes at most a programmed number of rising edges, each as a one-clock pulse. Further edges in that slot are folded into a single held event, which is released when the next slot begins.

Lines that no active pacer watches reach the output unchanged, with no register in the path. Configuration comes through a simple write-only register port. Address 0 holds the slot length. Address 1 holds the four line selections. Address 2 holds the four limits and their enable bits.

Top module: `irq_pacer`

## Requirements
- R1: A line that no active pacer owns drives `irq_out` combinationally from `irq_in` on the same cycle.
- R2: The slot boundary (tick) occurs on the clock where the prescale counter equals the prescale value, so a slot lasts value+1 clocks. The value resets to 499. Writing address 0 (`wr_data[15:0]`) loads a new value and restarts the counter from 0.
- R3: On an owned line, each rising edge of `irq_in` that arrives while the slot count is below the limit appears as a one-clock high pulse on `irq_out` on the following cycle, and it increments the count. While owned, the line shows only these pulses.
- R4: A rising edge that arrives once the count has reached the limit produces no pulse. Any number of such edges sets one held flag. At the next tick the held flag is released as a single pulse, which counts as the first event of the new slot. An edge that coincides with that tick stays held. Otherwise the count restarts at 0 on each tick.
- R5: Address 2 holds, for pacer p, a limit in bits [8p+5:8p] and an enable in bit 8p+7. A pacer is active only when it is enabled and its limit is 2 or more. A limit of 0 or 1 leaves the line unpaced, and the line then behaves as in R1.
- R6: When several active pacers select the same line, the lowest-numbered one owns it. The others keep no state until they become owners.
- R7: Address 1 holds pacer p's line selection in bits [8p+5:8p]. Writing a different selection clears that pacer's count and held flag, so a held event is lost. A pacer that is not an owner holds a zero count and no held flag.
- R8: A selection of 40 or more makes the pacer inactive, and every line stays unpaced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 slot length, 1 selections, 2 limits and enables |
| wr_data | input | 32 | Write data |
| irq_in | input | 40 | Raw interrupt lines |
| irq_out | output | 40 | Paced interrupt lines |

## Verification
The bench drives bursts larger than the limit. A pacer that counts wrongly would pass a third pulse, or would lose the merged event at the slot boundary. It selects one line from two pacers, then disables the lower one. A design with the wrong priority would pace with the higher limit, and one that kept stale state would release a phantom pulse. It rewrites a selection while an event is held, which catches a design that fires that event late. It also uses limits of 0 and 1, and selections beyond the last line. A design that treated these as pacing would swallow or delay edges that must pass straight through.

// File: rtl/irq_pacer.sv
module irq_pacer #(
  parameter int NCH     = 40,
  parameter int NPACE   = 4,
  parameter int SEL_W   = 6,
  parameter int MAX_W   = 6,
  parameter int PRE_W   = 16,
  parameter int PRE_RST = 499,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NCH-1:0]    irq_in,
  output logic [NCH-1:0]    irq_out
);
  localparam int FLD    = 8;
  localparam int EN_BIT = FLD - 1;

  logic [PRE_W-1:0] pre, pc;
  logic             tick;
  logic [NCH-1:0]   in_q, rise;
  logic [SEL_W-1:0] map_r [NPACE];
  logic [MAX_W-1:0] max_r [NPACE];
  logic [MAX_W-1:0] cnt   [NPACE];
  logic [NPACE-1:0] en_r, act, own, ev, map_chg, pend, pulse;

  assign tick = (pc == pre);
  assign rise = irq_in & ~in_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre  <= PRE_W'(PRE_RST);
      pc   <= '0;
      in_q <= '0;
    end else begin
      in_q <= irq_in;
      if (wr_en && wr_addr == 2'd0) begin
        pre <= wr_data[PRE_W-1:0];
        pc  <= '0;
      end else if (tick) pc <= '0;
      else pc <= pc + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPACE; p++) begin
        map_r[p] <= '0;
        max_r[p] <= '0;
      end
      en_r <= '0;
    end else if (wr_en) begin
      for (int p = 0; p < NPACE; p++) begin
        if (wr_addr == 2'd1) map_r[p] <= wr_data[p*FLD +: SEL_W];
        if (wr_addr == 2'd2) begin
          max_r[p] <= wr_data[p*FLD +: MAX_W];
          en_r[p]  <= wr_data[p*FLD + EN_BIT];
        end
      end
    end
  end

  always_comb begin
    for (int p = 0; p < NPACE; p++) begin
      act[p] = en_r[p] && (max_r[p] >= MAX_W'(2)) && (int'(map_r[p]) < NCH);
      map_chg[p] = wr_en && (wr_addr == 2'd1) && (wr_data[p*FLD +: SEL_W] != map_r[p]);
    end
    for (int p = 0; p < NPACE; p++) begin
      own[p] = act[p];
      ev[p]  = 1'b0;
      for (int q = 0; q < NPACE; q++)
        if (q < p && act[q] && map_r[q] == map_r[p]) own[p] = 1'b0;
      for (int c = 0; c < NCH; c++)
        if (int'(map_r[p]) == c) ev[p] = own[p] && rise[c];
    end
  end

  always_comb begin
    irq_out = irq_in;
    for (int p = 0; p < NPACE; p++)
      for (int c = 0; c < NCH; c++)
        if (own[p] && int'(map_r[p]) == c) irq_out[c] = pulse[p];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPACE; p++) cnt[p] <= '0;
      pend  <= '0;
      pulse <= '0;
    end else begin
      for (int p = 0; p < NPACE; p++) begin
        if (map_chg[p] || !own[p]) begin
          cnt[p]   <= '0;
          pend[p]  <= 1'b0;
          pulse[p] <= 1'b0;
        end else if (tick) begin
          if (pend[p]) begin
            pulse[p] <= 1'b1;
            cnt[p]   <= MAX_W'(1);
            pend[p]  <= ev[p];
          end else begin
            pulse[p] <= ev[p];
            cnt[p]   <= ev[p] ? MAX_W'(1) : '0;
          end
        end else if (ev[p]) begin
          if (cnt[p] < max_r[p]) begin
            pulse[p] <= 1'b1;
            cnt[p]   <= cnt[p] + 1'b1;
          end else begin
            pulse[p] <= 1'b0;
            pend[p]  <= 1'b1;
          end
        end else begin
          pulse[p] <= 1'b0;
        end
      end
    end
  end

  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pre != '0 && !(wr_en && wr_addr == 2'd0)) |=> !tick);

  a_r1_idle_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (own == '0) |-> (irq_out == irq_in));

  for (genvar g = 0; g < NPACE; g++) begin : g_chk
    a_r4_over_limit_held: assert property (@(posedge clk) disable iff (!rst_n)
      (own[g] && !tick && !map_chg[g] && ev[g] && cnt[g] >= max_r[g]) |=> (pend[g] && !pulse[g]));
    a_r4_tick_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && own[g] && !map_chg[g]) |=> (cnt[g] <= MAX_W'(1)));
    a_r7_idle_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (!own[g] || map_chg[g]) |=> (cnt[g] == '0 && !pend[g] && !pulse[g]));
    a_r3_pulse_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
      (own[g] && !tick && !ev[g]) |=> !pulse[g]);
  end
endmodule

// File: tb/tb_irq_pacer.sv
module tb_irq_pacer;
  localparam int NCH = 40;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic [NCH-1:0] irq_in = 0;
  logic [NCH-1:0] irq_out;

  irq_pacer dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                 .wr_data(wr_data), .irq_in(irq_in), .irq_out(irq_out));

  always #4 clk = ~clk;

  int nchk = 0, nbad = 0, pcount = 0, watch = 0;
  bit finished = 0;
  string cur_req = "R1";

  int m_pre, m_pc, m_map[4], m_max[4], m_cnt[4];
  bit m_en[4], m_pend[4], m_pulse[4];
  logic [NCH-1:0] m_prev;

  function automatic bit m_act(int p);
    return m_en[p] && m_max[p] >= 2 && m_map[p] < NCH;
  endfunction
  function automatic bit m_own(int p);
    if (!m_act(p)) return 0;
    for (int q = 0; q < p; q++) if (m_act(q) && m_map[q] == m_map[p]) return 0;
    return 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 499; m_pc = 0; m_prev = '0;
      for (int p = 0; p < 4; p++) begin
        m_map[p] = 0; m_max[p] = 0; m_en[p] = 0; m_cnt[p] = 0; m_pend[p] = 0; m_pulse[p] = 0;
      end
    end else begin
      bit tk, o[4], e[4];
      tk = (m_pc == m_pre);
      for (int p = 0; p < 4; p++) begin
        o[p] = m_own(p);
        e[p] = o[p] && irq_in[m_map[p]] && !m_prev[m_map[p]];
      end
      for (int p = 0; p < 4; p++) begin
        bit chg;
        chg = wr_en && wr_addr == 1 && int'((wr_data >> (8*p)) & 32'h3f) != m_map[p];
        if (chg || !o[p]) begin
          m_cnt[p] = 0; m_pend[p] = 0; m_pulse[p] = 0;
        end else if (tk) begin
          if (m_pend[p]) begin m_pulse[p] = 1; m_cnt[p] = 1; m_pend[p] = e[p]; end
          else begin m_pulse[p] = e[p]; m_cnt[p] = e[p] ? 1 : 0; end
        end else if (e[p]) begin
          if (m_cnt[p] < m_max[p]) begin m_pulse[p] = 1; m_cnt[p]++; end
          else begin m_pulse[p] = 0; m_pend[p] = 1; end
        end else m_pulse[p] = 0;
      end
      if (wr_en && wr_addr == 1)
        for (int p = 0; p < 4; p++) m_map[p] = int'((wr_data >> (8*p)) & 32'h3f);
      if (wr_en && wr_addr == 2)
        for (int p = 0; p < 4; p++) begin
          m_max[p] = int'((wr_data >> (8*p)) & 32'h3f);
          m_en[p]  = wr_data[8*p+7];
        end
      if (wr_en && wr_addr == 0) begin m_pre = int'(wr_data[15:0]); m_pc = 0; end
      else if (tk) m_pc = 0;
      else m_pc++;
      m_prev = irq_in;
    end
  end

  task automatic check(bit ok, string req, logic [NCH-1:0] act, logic [NCH-1:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [NCH-1:0] exp;
      exp = irq_in;
      for (int p = 0; p < 4; p++) if (m_own(p)) exp[m_map[p]] = m_pulse[p];
      check(irq_out === exp, cur_req, irq_out, exp);
      if (irq_out[watch]) pcount++;
    end
  end

  task automatic step(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask
  task automatic wr(int a, logic [31:0] d);
    wr_en = 1; wr_addr = 2'(a); wr_data = d; step(1); wr_en = 0;
  endtask
  task automatic pulse_in(int ch);
    irq_in[ch] = 1; step(1); irq_in[ch] = 0; step(1);
  endtask
  task automatic expect_count(int exp, string req);
    check(pcount == exp, req, NCH'(pcount), NCH'(exp));
  endtask

  initial begin
    #(8*150000);
    if (!finished) begin
      nbad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    step(3);
    check(irq_out === '0, "R1 reset", irq_out, '0);
    rst_n = 1; step(1);

    // R2: reset slot length 500 clocks
    cur_req = "R2"; watch = 2;
    wr(1, 32'h02); wr(2, 32'h82);
    pcount = 0;
    pulse_in(2); pulse_in(2); pulse_in(2);
    step(90);
    expect_count(2, "R2 before first tick");
    step(420);
    expect_count(3, "R2 held event at reset-length tick");

    // R3/R4: slot of 20 clocks, limit 2 on line 5
    cur_req = "R3"; watch = 5;
    wr(0, 32'd19); wr(1, 32'h05); wr(2, 32'h82);
    pcount = 0;
    pulse_in(5); pulse_in(5); pulse_in(5); pulse_in(5);
    step(6);
    expect_count(2, "R3 limit per slot");
    cur_req = "R4"; pcount = 0;
    step(10);
    expect_count(1, "R4 merged excess released once");
    step(40);

    // R1: unpaced line same cycle
    cur_req = "R1";
    irq_in[20] = 1; #1;
    check(irq_out[20] === 1'b1, "R1 passthrough", irq_out, irq_in);
    step(1); irq_in[20] = 0; step(1);

    // R5: limit 1 and 0 unpaced
    cur_req = "R5"; wr(2, 32'h81); pcount = 0;
    pulse_in(5); pulse_in(5); pulse_in(5);
    expect_count(3, "R5 limit one passes all");
    wr(2, 32'h80); pcount = 0;
    pulse_in(5); pulse_in(5);
    expect_count(2, "R5 limit zero passes all");

    // R6: two pacers on line 7
    cur_req = "R6"; watch = 7;
    wr(0, 32'd19); wr(1, 32'h0707); wr(2, 32'h8382);
    pcount = 0;
    for (int i = 0; i < 4; i++) pulse_in(7);
    expect_count(2, "R6 lower pacer owns");
    step(30);
    wr(2, 32'h8300);
    for (int i = 0; i < 30; i++) begin
      if (i % 3 == 0) irq_in[7] = ~irq_in[7];
      step(1);
    end
    irq_in[7] = 0; step(40);

    // R7: remap while held
    cur_req = "R7"; watch = 9;
    wr(0, 32'd19); wr(1, 32'h09); wr(2, 32'h82);
    pulse_in(9); pulse_in(9); pulse_in(9);
    wr(1, 32'h0a);
    pcount = 0; step(25);
    expect_count(0, "R7 held event dropped on remap");

    // R8: out-of-range selection
    cur_req = "R8"; watch = 13;
    wr(1, 32'h2d2d2d2d); wr(2, 32'h85858585);
    pcount = 0;
    pulse_in(13); pulse_in(13);
    expect_count(2, "R8 no line paced");
    step(5);

    // R3/R4/R6 random traffic
    cur_req = "R3 R4 random";
    wr(0, 32'd7); wr(1, 32'h1e0b0b03); wr(2, 32'h85bf8482);
    for (int i = 0; i < 3000; i++) begin
      irq_in = irq_in ^ (NCH'({$urandom, $urandom}) & NCH'({$urandom, $urandom}) & NCH'({$urandom, $urandom}));
      if (i == 1500) wr(1, 32'h031e0b03);
      else step(1);
    end
    irq_in = '0; step(20);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule